// File: doc/BRIEF.md
# Serial Memory Write Guard

This block sits beside the command engine of a 512K x 8 serial memory. It decides whether each pending write may proceed. It holds the protection state: a two-bit region code, a write-protect-enable bit and a write-enable latch. For each write request it samples the external write-protect pin, the kind of write and the 19-bit target address, and it answers with a registered grant or deny flag one cycle later.

The command engine raises one request strobe for each byte it is about to store. After an address auto-increment, each new byte address is checked against the protected region again. Separate strobes set and clear the write-enable latch. A completion strobe ends a write command. If at least one byte of that command was granted, the completion strobe drops the latch. A granted status-register write loads the new region code and the new protect-enable bit.

Top module: `spi_wr_guard`

## Requirements
- R1: After reset, the write-enable latch, the region code, the protect-enable bit, grant and deny are all 0.
- R2: A set strobe makes the latch 1 at the next edge. A clear strobe makes it 0 at the next edge and wins over a set strobe in the same cycle.
- R3: While the latch is 0, every request is denied, whatever its kind, address or pin.
- R4: Region code 0 protects nothing. Code 1 protects byte addresses 0x60000 to 0x7FFFF. Code 2 protects 0x40000 to 0x7FFFF. Code 3 protects the whole array. An array write to a protected address is denied even when the latch is 1.
- R5: With the latch at 1, an array write to an unprotected address is granted, whatever the protect-enable bit and the pin are.
- R6: A status write (kind code 3) with the latch at 1 is granted when protect-enable is 0. When protect-enable is 1, it is granted only if the pin is 1. Its address is not checked.
- R7: A granted status write loads the region code from `sr_bp_i` and protect-enable from `sr_wpen_i` at the same edge as the grant. Any other cycle leaves both bits unchanged.
- R8: Kind codes 0 (single write), 1 (quad-data write) and 2 (quad-address write) are all array writes and are judged identically.
- R9: A completion strobe clears the latch only if a request was granted after the latch was last cleared and before this strobe. Otherwise the strobe leaves the latch unchanged. A clear caused by completion also wins over a set strobe in the same cycle.
- R10: Exactly one of grant and deny is 1 in the cycle after a request strobe. Both are 0 in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wel_set_i | input | 1 | Set-enable strobe |
| wel_clr_i | input | 1 | Clear-enable strobe |
| wr_done_i | input | 1 | Write command completed strobe |
| req_i | input | 1 | Write request strobe, one per byte |
| req_kind_i | input | 2 | 0 single, 1 quad data, 2 quad address, 3 status write |
| req_addr_i | input | 19 | Byte address of this request |
| wp_pin_i | input | 1 | External write-protect pin level |
| sr_bp_i | input | 2 | Region code carried by a status write |
| sr_wpen_i | input | 1 | Protect-enable carried by a status write |
| grant_o | output | 1 | Request granted (one cycle after the request) |
| deny_o | output | 1 | Request denied (one cycle after the request) |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 2 | Current region code |
| wpen_o | output | 1 | Current protect-enable bit |

## Verification
Some rules are checked on every cycle. Each request gets exactly one response. A latch at 0 or a region code of 3 forces a deny. A status write with protect-enable set and the pin low is denied. The clear strobe always drops the latch. The protection bits move only on a status write. Other rules can be shown only by the bench's scenarios. These are the exact boundaries at 0x3FFFF/0x40000 and 0x5FFFF/0x60000, the equal treatment of the three array kinds, and the arming rule that decides whether a completion strobe drops the latch. The bench checks these against its reference model across directed and random sequences.

// File: rtl/wg_pkg.sv
package wg_pkg;

    localparam int unsigned KIND_W = 2;
    localparam int unsigned BP_W   = 2;

    typedef enum logic [KIND_W-1:0] {
        WK_SINGLE = 2'd0,
        WK_QDATA  = 2'd1,
        WK_QADDR  = 2'd2,
        WK_STATUS = 2'd3
    } wr_kind_e;

    typedef enum logic [BP_W-1:0] {
        RG_NONE    = 2'd0,
        RG_QUARTER = 2'd1,
        RG_HALF    = 2'd2,
        RG_ALL     = 2'd3
    } region_e;

    typedef struct packed {
        logic            wel;
        logic [BP_W-1:0] bp;
        logic            wpen;
        logic            armed;
        logic            grant;
        logic            deny;
    } guard_st_t;

endpackage

// File: rtl/wg_region.sv
module wg_region
    import wg_pkg::*;
#(
    parameter int unsigned ADDR_W = 19
) (
    input  logic [BP_W-1:0]   code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);
    localparam int unsigned TOP = ADDR_W - 1;

    logic upper_half;
    logic upper_quarter;

    // The top address bits select the half or the quarter of the array.
    assign upper_half    = addr_i[TOP];
    assign upper_quarter = addr_i[TOP] & addr_i[TOP-1];

    always_comb begin
        unique case (region_e'(code_i))
            RG_NONE:    prot_o = 1'b0;
            RG_QUARTER: prot_o = upper_quarter;
            RG_HALF:    prot_o = upper_half;
            default:    prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wg_decide.sv
module wg_decide
    import wg_pkg::*;
(
    input  logic              kind_status_i,
    input  logic              wel_i,
    input  logic              wpen_i,
    input  logic              pin_i,
    input  logic              prot_i,
    output logic              ok_o
);
    logic status_ok;
    logic array_ok;

    // A status write depends on the pin only when protect-enable is set.
    assign status_ok = !wpen_i || pin_i;
    // An array write depends only on the region check.
    assign array_ok  = !prot_i;

    always_comb begin
        if (!wel_i) begin
            ok_o = 1'b0;
        end else if (kind_status_i) begin
            ok_o = status_ok;
        end else begin
            ok_o = array_ok;
        end
    end
endmodule

// File: rtl/spi_wr_guard.sv
module spi_wr_guard
    import wg_pkg::*;
#(
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              wr_done_i,
    input  logic              req_i,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              wp_pin_i,
    input  logic [1:0]        sr_bp_i,
    input  logic              sr_wpen_i,
    output logic              grant_o,
    output logic              deny_o,
    output logic              wel_o,
    output logic [1:0]        bp_o,
    output logic              wpen_o
);
    guard_st_t st_d, st_q;

    logic is_status;
    logic prot;
    logic ok;

    assign is_status = (wr_kind_e'(req_kind_i) == WK_STATUS);

    wg_region #(.ADDR_W(ADDR_W)) u_region (
        .code_i (st_q.bp),
        .addr_i (req_addr_i),
        .prot_o (prot)
    );

    wg_decide u_decide (
        .kind_status_i (is_status),
        .wel_i         (st_q.wel),
        .wpen_i        (st_q.wpen),
        .pin_i         (wp_pin_i),
        .prot_i        (prot),
        .ok_o          (ok)
    );

    always_comb begin
        logic granted;
        st_d    = st_q;
        granted = req_i && ok;

        st_d.grant = granted;
        st_d.deny  = req_i && !ok;

        if (granted && is_status) begin
            st_d.bp   = sr_bp_i;
            st_d.wpen = sr_wpen_i;
        end

        // The latch is armed by any grant. It is disarmed when the command completes or the latch is cleared.
        st_d.armed = (st_q.armed && !wr_done_i && !wel_clr_i) || granted;

        if (wel_clr_i || (wr_done_i && st_q.armed)) begin
            st_d.wel = 1'b0;
        end else if (wel_set_i) begin
            st_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = st_q.grant;
    assign deny_o  = st_q.deny;
    assign wel_o   = st_q.wel;
    assign bp_o    = st_q.bp;
    assign wpen_o  = st_q.wpen;

    a_r10_one_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> (grant_o ^ deny_o));
    a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> (!grant_o && !deny_o));
    a_r3_latch_low_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !wel_o) |=> deny_o);
    a_r4_full_region_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !is_status && bp_o == 2'd3) |=> deny_o);
    a_r6_pin_low_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && is_status && wpen_o && !wp_pin_i) |=> deny_o);
    a_r2_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wel_clr_i |=> !wel_o);
    a_r2_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wel_set_i && !wel_clr_i && !wr_done_i) |=> wel_o);
    a_r7_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && is_status) |=> ($stable(bp_o) && $stable(wpen_o)));
endmodule

// File: tb/spi_wr_guard_tb.sv
module spi_wr_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_s = 0, clr_s = 0, done_s = 0, req = 0, pin = 0, srw = 0;
    logic [1:0]  kind = 0, srbp = 0;
    logic [18:0] addr = 0;
    logic        grant, deny, wel, wpen;
    logic [1:0]  bp;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int m_wel = 0, m_bp = 0, m_wpen = 0, m_armed = 0, m_grant = 0, m_deny = 0;

    always #2 clk = ~clk;

    spi_wr_guard u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wel_set_i(set_s), .wel_clr_i(clr_s),
        .wr_done_i(done_s), .req_i(req), .req_kind_i(kind), .req_addr_i(addr),
        .wp_pin_i(pin), .sr_bp_i(srbp), .sr_wpen_i(srw),
        .grant_o(grant), .deny_o(deny), .wel_o(wel), .bp_o(bp), .wpen_o(wpen)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int region_hit(input int code, input int a);
        case (code)
            0: return 0;
            1: return (a >= 'h60000) ? 1 : 0;
            2: return (a >= 'h40000) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    task automatic model_step();
        int ok;
        int n_wel;
        ok = 0;
        if (req) begin
            if (kind == 3) ok = (m_wel && (!m_wpen || pin)) ? 1 : 0;
            else ok = (m_wel && !region_hit(m_bp, addr)) ? 1 : 0;
        end
        n_wel = m_wel;
        if (clr_s || (done_s && m_armed)) n_wel = 0;
        else if (set_s) n_wel = 1;
        m_armed = ((m_armed && !done_s && !clr_s) || (req && ok)) ? 1 : 0;
        if (req && ok && kind == 3) begin
            m_bp = srbp;
            m_wpen = srw;
        end
        m_wel = n_wel;
        m_grant = (req && ok) ? 1 : 0;
        m_deny = (req && !ok) ? 1 : 0;
    endtask

    task automatic compare(input string tag);
        chk({tag, " grant"}, grant, m_grant);
        chk({tag, " deny"}, deny, m_deny);
        chk({tag, " wel"}, wel, m_wel);
        chk({tag, " bp"}, bp, m_bp);
        chk({tag, " wpen"}, wpen, m_wpen);
    endtask

    // Inputs are driven just after an edge. The model advances on the next edge, and outputs are compared 1 ns later.
    task automatic cyc(input string tag, input bit s, input bit c, input bit d,
                       input bit r, input int k, input int a, input bit p,
                       input int b, input bit w);
        set_s = s; clr_s = c; done_s = d; req = r; kind = k[1:0];
        addr = a[18:0]; pin = p; srbp = b[1:0]; srw = w;
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
    endtask

    task automatic idle(); cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 wel", wel, 0); chk("R1 bp", bp, 0); chk("R1 wpen", wpen, 0);
        chk("R1 grant", grant, 0); chk("R1 deny", deny, 0);
        rst_n = 1'b1;
        idle();

        // R3: latch low, every kind denied
        for (int k = 0; k < 4; k++) begin
            cyc("R3", 0, 0, 0, 1, k, 'h00010, 1, 0, 0);
            chk("R3 deny", deny, 1);
        end
        // R2: set, clear, clear wins
        cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0); chk("R2 set", wel, 1);
        cyc("R2", 0, 1, 0, 0, 0, 0, 0, 0, 0); chk("R2 clr", wel, 0);
        cyc("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0); chk("R2 clr wins", wel, 0);
        // R9: done without a grant keeps the latch
        cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 1, 0, 0, 0, 0, 0, 0); chk("R9 unarmed done", wel, 1);
        // R5/R8: unprotected array writes, all kinds, any pin
        for (int k = 0; k < 3; k++) begin
            cyc("R8", 0, 0, 0, 1, k, 'h7FFFF, k[0], 0, 0);
            chk("R5 R8 grant", grant, 1);
        end
        // R9: armed done clears the latch even with set
        cyc("R9", 1, 0, 1, 0, 0, 0, 0, 0, 0); chk("R9 armed done", wel, 0);
        // R6/R7: status write with wpen 0 loads code 1 and wpen 1
        cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 1, 3, 'h7FFFF, 0, 1, 1);
        chk("R6 wpen0 grant", grant, 1); chk("R7 bp", bp, 1); chk("R7 wpen", wpen, 1);
        // R4: quarter boundary
        cyc("R4", 0, 0, 0, 1, 0, 'h5FFFF, 0, 0, 0); chk("R4 5FFFF", grant, 1);
        cyc("R4", 0, 0, 0, 1, 1, 'h60000, 0, 0, 0); chk("R4 60000", deny, 1);
        // R6: wpen 1, pin 0 denied, and the bits stay put
        cyc("R6", 0, 0, 0, 1, 3, 0, 0, 2, 0);
        chk("R6 pin0 deny", deny, 1); chk("R7 kept", bp, 1);
        cyc("R6", 0, 0, 0, 1, 3, 0, 1, 2, 1);
        chk("R6 pin1 grant", grant, 1); chk("R7 half", bp, 2);
        cyc("R4", 0, 0, 0, 1, 2, 'h3FFFF, 0, 0, 0); chk("R4 3FFFF", grant, 1);
        cyc("R4", 0, 0, 0, 1, 2, 'h40000, 1, 0, 0); chk("R4 40000", deny, 1);
        cyc("R6", 0, 0, 0, 1, 3, 0, 1, 3, 0); chk("R7 all", bp, 3);
        cyc("R4", 0, 0, 0, 1, 0, 'h00000, 1, 0, 0); chk("R4 all deny", deny, 1);
        idle();
        chk("R10 quiet", grant | deny, 0);

        // random phase, model compared every clock
        for (int i = 0; i < 4000; i++) begin
            int u;
            u = $urandom;
            cyc("R10 rand", (u % 7) == 0, (u % 23) == 0, (u % 11) == 0,
                ((u >> 4) % 3) != 0, (u >> 6) & 3,
                ((u >> 9) & 1) ? ('h3FFF0 + ((u >> 10) & 'h3F)) : ((u >> 10) & 'h7FFFF),
                (u >> 29) & 1, (u >> 30) & 3, (u >> 8) & 1);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule